// File: doc/BRIEF.md
# Dual-Mode Segment Address Translator

This block turns a segment register value and a 16-bit offset into a 24-bit physical address. It starts in real mode after reset. In real mode the segment value is shifted left by four bits and added to the offset. Only 20 address bits are kept, so a sum past 1 MB wraps back to the low range, and the top four output bits are zero. A single pulse on `pe_set` moves the block into protected mode. Only reset brings it back to real mode.

In protected mode the segment value is a selector. It picks an 8-byte descriptor from the global table or the local table. The block reads the descriptor through a memory read port that uses a valid/ready handshake. It keeps the descriptor in a shadow entry tied to that segment register. It then checks the table bound, the present bit, the privilege level and the segment limit, and adds the descriptor base to the offset.

A control FSM has three states: `ST_IDLE`, `ST_FETCH` and `ST_DONE`. Its transitions are:
- `ST_IDLE` to `ST_DONE` on a request that needs no read. This covers real mode, a shadow hit and a table-bound fault.
- `ST_IDLE` to `ST_FETCH` on a shadow miss.
- `ST_FETCH` to `ST_DONE` when `mem_ready` is high.
- `ST_DONE` to `ST_IDLE` always.

`done` is high for the one cycle spent in `ST_DONE`. A request in which the block samples `req_valid` at a clock edge in `ST_IDLE` without a memory read shows `done` in the very next cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset `busy`, `done` and `mem_valid` are low, `msw` is 0 and the block is in real mode.
- R2: In real mode the result is (segment × 16 + offset) modulo 2^20, with `phys_addr[23:20]` = 0. The result has fault code 0, makes no memory read, and `done` is high in the cycle after the request edge.
- R3: A `pe_set` pulse sets `msw[0]` (protected mode). `msw[0]` then stays 1 through later `pe_set` pulses and translations until reset. Entering protected mode empties every shadow entry.
- R4: A selector carries the descriptor index in bits 15:3, a table bit in bit 2 (0 = global, 1 = local) and the requested privilege in bits 1:0. A descriptor read is issued to address table base + index × 8.
- R5: When index × 8 + 7 is greater than the chosen table limit, the result is fault code 1 and no memory read is made.
- R6: A descriptor has the limit in bits 15:0, the base in bits 39:16, the present flag in bit 47 and the descriptor privilege in bits 46:45. A passing translation returns (base + offset) modulo 2^24 with fault code 0 and `addr_ok` high.
- R7: An offset greater than the segment limit gives fault code 2.
- R8: A clear present bit gives fault code 3. A requested privilege numerically lower than the descriptor privilege gives fault code 4. The checks take priority in the order table bound, present, privilege, limit. On any fault `phys_addr` is 0 and `addr_ok` is low.
- R9: While a segment register is not reloaded, later protected translations through it reuse the shadow entry with no memory read. Reloading the register forces a new read.
- R10: `mem_valid` stays high with a stable `mem_addr` until `mem_ready`. `done` follows in the cycle after the `mem_ready` edge.
- R11: A request made while `busy` is high is ignored and produces no `done`. `done` never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pe_set | input | 1 | Pulse to enter protected mode |
| seg_load | input | 1 | Load a segment register (taken when idle) |
| seg_load_idx | input | 2 | Segment register to load |
| seg_load_val | input | 16 | Segment value or selector |
| req_valid | input | 1 | Translation request (taken when idle) |
| req_seg | input | 2 | Segment register used by the request |
| req_offset | input | 16 | Offset within the segment |
| gtab_base | input | 24 | Global table base |
| gtab_limit | input | 16 | Global table limit in bytes |
| ltab_base | input | 24 | Local table base |
| ltab_limit | input | 16 | Local table limit in bytes |
| mem_valid | output | 1 | Descriptor read request |
| mem_addr | output | 24 | Descriptor address |
| mem_ready | input | 1 | Read accepted; data valid this cycle |
| mem_rdata | input | 48 | Descriptor contents |
| busy | output | 1 | Translation in progress |
| done | output | 1 | One-cycle result pulse |
| addr_ok | output | 1 | Result is a valid address |
| phys_addr | output | 24 | Physical address (0 on fault) |
| fault_code | output | 3 | 0 none, 1 table, 2 limit, 3 absent, 4 privilege |
| msw | output | 16 | Machine status word, bit 0 = protected mode |

## Verification
The bench first goes after the real-mode wrap past 1 MB. A design that kept a 21st bit would return 0x100000 or 0x10FFEF where 0x000000 and 0x0FFEF are due. It then aims at descriptors that fail several checks at once. A design with the wrong priority would report a limit fault where an absent or privilege fault is due. Shadow reuse and invalidation are tracked by counting memory reads: a design that never caches reads on every request, and one that misses the invalidation on reload returns a stale base. A request pushed in during a slow fetch exposes a design that accepts work while busy, because it emits an extra `done` that the scoreboard does not expect.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int SEL_W  = 16;
    localparam int OFF_W  = 16;
    localparam int PA_W   = 24;
    localparam int RA_W   = 20;
    localparam int DESC_W = 48;

    typedef struct packed {
        logic             present;
        logic [1:0]       dpl;
        logic [4:0]       rsvd;
        logic [PA_W-1:0]  base;
        logic [OFF_W-1:0] limit;
    } desc_t;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_TABLE  = 3'd1,
        FLT_LIMIT  = 3'd2,
        FLT_ABSENT = 3'd3,
        FLT_PRIV   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } state_e;
endpackage

// File: rtl/xlate_shadow.sv
module xlate_shadow
    import xlate_pkg::*;
#(
    parameter int NSEG  = 4,
    localparam int IDX_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  desc_t            fill_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_hit,
    output desc_t            rd_desc
);
    logic  [NSEG-1:0] vld_q;
    desc_t            ent_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                ent_q[g] <= '0;
            end else if (inv_all || (inv_en && inv_idx == IDX_W'(g))) begin
                vld_q[g] <= 1'b0;
            end else if (fill_en && fill_idx == IDX_W'(g)) begin
                vld_q[g] <= 1'b1;
                ent_q[g] <= fill_desc;
            end
        end
    end

    assign rd_hit  = vld_q[rd_idx];
    assign rd_desc = ent_q[rd_idx];
endmodule

// File: rtl/xlate_eval.sv
module xlate_eval
    import xlate_pkg::*;
(
    input  logic             prot,
    input  logic [SEL_W-1:0] sel,
    input  logic [OFF_W-1:0] off,
    input  desc_t            desc,
    output logic [PA_W-1:0]  addr,
    output fault_e           code
);
    logic [RA_W-1:0] real_sum;

    always_comb begin
        real_sum = {sel, 4'b0000} + {{(RA_W-OFF_W){1'b0}}, off};
        addr     = '0;
        code     = FLT_NONE;
        if (!prot) begin
            addr = {{(PA_W-RA_W){1'b0}}, real_sum};
        end else if (!desc.present) begin
            code = FLT_ABSENT;
        end else if (sel[1:0] < desc.dpl) begin
            code = FLT_PRIV;
        end else if (off > desc.limit) begin
            code = FLT_LIMIT;
        end else begin
            addr = desc.base + {{(PA_W-OFF_W){1'b0}}, off};
        end
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import xlate_pkg::*;
#(
    parameter int NSEG = 4,
    localparam int IDX_W = $clog2(NSEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pe_set,
    input  logic              seg_load,
    input  logic [IDX_W-1:0]  seg_load_idx,
    input  logic [SEL_W-1:0]  seg_load_val,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [PA_W-1:0]   gtab_base,
    input  logic [OFF_W-1:0]  gtab_limit,
    input  logic [PA_W-1:0]   ltab_base,
    input  logic [OFF_W-1:0]  ltab_limit,
    output logic              mem_valid,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_ready,
    input  logic [DESC_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              addr_ok,
    output logic [PA_W-1:0]   phys_addr,
    output logic [2:0]        fault_code,
    output logic [15:0]       msw
);
    state_e           state_q, state_d;
    logic [SEL_W-1:0] seg_q [NSEG];
    logic             pe_q;
    logic [IDX_W-1:0] cur_q;
    logic [OFF_W-1:0] off_q;
    logic [PA_W-1:0]  fetch_q, fetch_d;
    logic [PA_W-1:0]  res_addr_q, res_addr_d;
    fault_e           res_code_q, res_code_d;
    logic             capture;

    logic             sh_hit, fill_en;
    desc_t            sh_desc, ev_desc;
    logic [SEL_W-1:0] req_sel, ev_sel;
    logic [OFF_W-1:0] ev_off;
    logic [PA_W-1:0]  ev_addr;
    fault_e           ev_code;
    logic [PA_W-1:0]  tab_base;
    logic [OFF_W-1:0] tab_limit, tab_end;
    logic             tab_fault;
    logic             load_ok;

    assign req_sel   = seg_q[req_seg];
    assign tab_base  = req_sel[2] ? ltab_base  : gtab_base;
    assign tab_limit = req_sel[2] ? ltab_limit : gtab_limit;
    assign tab_end   = {req_sel[15:3], 3'b111};
    assign tab_fault = tab_end > tab_limit;
    assign load_ok   = seg_load && state_q == ST_IDLE;
    assign fill_en   = state_q == ST_FETCH && mem_ready;

    xlate_shadow #(.NSEG(NSEG)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_all   (pe_set && !pe_q),
        .inv_en    (load_ok),
        .inv_idx   (seg_load_idx),
        .fill_en   (fill_en),
        .fill_idx  (cur_q),
        .fill_desc (desc_t'(mem_rdata)),
        .rd_idx    (req_seg),
        .rd_hit    (sh_hit),
        .rd_desc   (sh_desc)
    );

    assign ev_desc = (state_q == ST_FETCH) ? desc_t'(mem_rdata) : sh_desc;
    assign ev_sel  = (state_q == ST_FETCH) ? seg_q[cur_q] : req_sel;
    assign ev_off  = (state_q == ST_FETCH) ? off_q : req_offset;

    xlate_eval u_eval (
        .prot (pe_q),
        .sel  (ev_sel),
        .off  (ev_off),
        .desc (ev_desc),
        .addr (ev_addr),
        .code (ev_code)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and result selection
    always_comb begin
        state_d    = state_q;
        capture    = 1'b0;
        res_addr_d = ev_addr;
        res_code_d = ev_code;
        fetch_d    = tab_base + {{(PA_W-OFF_W){1'b0}}, req_sel[15:3], 3'b000};
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!pe_q || sh_hit) begin
                        capture = 1'b1;
                        state_d = ST_DONE;
                    end else if (tab_fault) begin
                        capture    = 1'b1;
                        res_addr_d = '0;
                        res_code_d = FLT_TABLE;
                        state_d    = ST_DONE;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_ready) begin
                    capture = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_q       <= 1'b0;
            cur_q      <= '0;
            off_q      <= '0;
            fetch_q    <= '0;
            res_addr_q <= '0;
            res_code_q <= FLT_NONE;
            for (int i = 0; i < NSEG; i++) seg_q[i] <= '0;
        end else begin
            if (pe_set) pe_q <= 1'b1;
            if (load_ok) seg_q[seg_load_idx] <= seg_load_val;
            if (state_q == ST_IDLE && req_valid) begin
                cur_q   <= req_seg;
                off_q   <= req_offset;
                fetch_q <= fetch_d;
            end
            if (capture) begin
                res_addr_q <= res_addr_d;
                res_code_q <= res_code_d;
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = state_q != ST_IDLE;
        done       = state_q == ST_DONE;
        mem_valid  = state_q == ST_FETCH;
        mem_addr   = fetch_q;
        phys_addr  = res_addr_q;
        fault_code = res_code_q;
        addr_ok    = done && res_code_q == FLT_NONE;
        msw        = {15'd0, pe_q};
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_valid && !done));
    // R3
    pe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msw[0] |=> msw[0]);
    // R10
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code != 3'd0) |-> (phys_addr == '0 && !addr_ok));
    // R2
    real_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !msw[0]) |-> (phys_addr[23:20] == 4'h0));
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pe_set = 1'b0, seg_load = 1'b0, req_valid = 1'b0;
    logic [1:0]  seg_load_idx = '0, req_seg = '0;
    logic [15:0] seg_load_val = '0, req_offset = '0;
    logic [23:0] gtab_base = 24'h100000, ltab_base = 24'h200000;
    logic [15:0] gtab_limit = 16'h00FF, ltab_limit = 16'h001F;
    logic        mem_valid, mem_ready = 1'b0;
    logic [23:0] mem_addr;
    logic [47:0] mem_rdata = '0;
    logic        busy, done, addr_ok;
    logic [23:0] phys_addr;
    logic [2:0]  fault_code;
    logic [15:0] msw;

    seg_xlate u_dut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0, n_reads = 0, n_done = 0, lat = 0, wcnt = 0;
    logic [23:0] last_addr = '0, first_addr = '0;
    logic        in_read = 1'b0;
    logic [47:0] dmem [logic [23:0]];
    logic [23:0] q_addr [$];
    logic [2:0]  q_code [$];
    string       q_tag  [$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] mkdesc(input logic [23:0] b, input logic [15:0] l, input bit p, input logic [1:0] d);
        return {p, d, 5'b0, b, l};
    endfunction

    // memory model
    always @(negedge clk) begin
        if (mem_valid && !mem_ready) begin
            if (!in_read) begin
                first_addr = mem_addr;
                in_read = 1'b1;
            end
            if (wcnt >= lat) begin
                check(mem_addr == first_addr, "R10 addr stable", mem_addr, first_addr);
                mem_ready = 1'b1;
                mem_rdata = dmem.exists(mem_addr) ? dmem[mem_addr] : 48'h0;
                last_addr = mem_addr;
                n_reads++;
                wcnt = 0;
                in_read = 1'b0;
            end else begin
                wcnt++;
            end
        end else begin
            mem_ready = 1'b0;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (q_addr.size() == 0) begin
                check(1'b0, "R11 unexpected done", 1, 0);
            end else begin
                logic [23:0] ea;
                logic [2:0]  ec;
                string       t;
                ea = q_addr.pop_front();
                ec = q_code.pop_front();
                t  = q_tag.pop_front();
                check(phys_addr == ea, {t, " addr"}, phys_addr, ea);
                check(fault_code == ec, {t, " code"}, fault_code, ec);
                check(addr_ok == (ec == 3'd0), {t, " ok"}, addr_ok, ec == 3'd0);
            end
        end
    end

    task automatic load(input logic [1:0] i, input logic [15:0] v);
        @(negedge clk);
        seg_load = 1'b1; seg_load_idx = i; seg_load_val = v;
        @(negedge clk);
        seg_load = 1'b0;
    endtask

    task automatic xlate(input logic [1:0] s, input logic [15:0] off, input logic [23:0] ea,
                         input logic [2:0] ec, input string tag);
        q_addr.push_back(ea); q_code.push_back(ec); q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_seg = s; req_offset = off;
        @(negedge clk);
        req_valid = 1'b0;
        while (q_addr.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int r0;
        dmem[24'h100010] = mkdesc(24'h123400, 16'h0FFF, 1'b1, 2'd0);
        dmem[24'h200018] = mkdesc(24'hFFFF00, 16'hFFFF, 1'b1, 2'd3);
        dmem[24'h100028] = mkdesc(24'h050000, 16'h0010, 1'b0, 2'd3);
        dmem[24'h100030] = mkdesc(24'h060000, 16'h0010, 1'b1, 2'd2);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !mem_valid, "R1 idle outputs", {busy, done, mem_valid}, 0);
        check(msw == 16'h0, "R1 msw", msw, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 real mode
        load(0, 16'h0400);
        load(1, 16'h0000);
        load(2, 16'hFFFF);
        xlate(0, 16'h0000, 24'h004000, 3'd0, "R2 0400:0000");
        xlate(1, 16'h4000, 24'h004000, 3'd0, "R2 0000:4000");
        xlate(2, 16'h0010, 24'h000000, 3'd0, "R2 wrap FFFF:0010");
        xlate(2, 16'hFFFF, 24'h00FFEF, 3'd0, "R2 wrap FFFF:FFFF");
        check(n_reads == 0, "R2 no reads", n_reads, 0);

        // R3 enter protected mode
        @(negedge clk); pe_set = 1'b1; @(negedge clk); pe_set = 1'b0;
        check(msw == 16'h0001, "R3 msw set", msw, 1);

        // R4 R6 global descriptor read
        load(0, 16'h0010);
        xlate(0, 16'h0100, 24'h123500, 3'd0, "R6 global");
        check(last_addr == 24'h100010, "R4 desc addr", last_addr, 24'h100010);
        // R9 shadow reuse
        r0 = n_reads;
        xlate(0, 16'h0FFF, 24'h1243FF, 3'd0, "R9 reuse");
        check(n_reads == r0, "R9 no reread", n_reads, r0);
        // R7 limit
        xlate(0, 16'h1000, 24'h0, 3'd2, "R7 over limit");
        // R4 R6 local table, base wrap
        load(1, 16'h001F);
        xlate(1, 16'h0200, 24'h000100, 3'd0, "R6 local wrap");
        check(last_addr == 24'h200018, "R4 local addr", last_addr, 24'h200018);
        // R5 table bound
        r0 = n_reads;
        load(2, 16'h0024);
        xlate(2, 16'h0000, 24'h0, 3'd1, "R5 table bound");
        check(n_reads == r0, "R5 no read", n_reads, r0);
        // R8 absent beats privilege and limit
        load(3, 16'h0028);
        xlate(3, 16'h0020, 24'h0, 3'd3, "R8 absent");
        // R8 privilege beats limit
        load(2, 16'h0031);
        xlate(2, 16'h0020, 24'h0, 3'd4, "R8 privilege");
        // R9 reload forces read, R10 slow handshake
        lat = 3;
        r0 = n_reads;
        load(2, 16'h0032);
        xlate(2, 16'h0008, 24'h060008, 3'd0, "R10 slow fetch");
        check(n_reads == r0 + 1, "R9 reload reread", n_reads, r0 + 1);

        // R11 request while busy ignored
        load(0, 16'h0010);
        r0 = n_done;
        q_addr.push_back(24'h123401); q_code.push_back(3'd0); q_tag.push_back("R11 first");
        @(negedge clk); req_valid = 1'b1; req_seg = 0; req_offset = 16'h0001;
        @(negedge clk); req_seg = 1; req_offset = 16'h0002;
        @(negedge clk); req_valid = 1'b0;
        repeat (10) @(negedge clk);
        check(n_done == r0 + 1, "R11 one done", n_done, r0 + 1);

        // R3 sticky, reset returns real mode
        @(negedge clk); pe_set = 1'b1; @(negedge clk); pe_set = 1'b0;
        check(msw == 16'h0001, "R3 still set", msw, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(msw == 16'h0, "R3 reset clears", msw, 0);
        xlate(0, 16'h1234, 24'h001234, 3'd0, "R3 real after reset");
        finish_run();
    end
endmodule